// File: doc/BRIEF.md
# Bus Access Dead-Time Limiter

This block sits between the request logic of a bus master engine and that engine's bus port. It limits how much of a shared interconnect the master can use. After every completed access it holds back the next access for a software-set number of idle bus-clock cycles. The gap is an 8-bit value, so it can be anywhere from 0 to 255 cycles. The counter runs on the same clock as the master port.

The engine offers a request through a valid/ready handshake. A request that arrives during the idle gap is held, not dropped. It is issued in the first cycle the gap allows. The bus reports the end of each access with a one-cycle completion pulse. A single enable input turns the limiter on. When the limiter is off, or when the gap value is zero, a new access may be issued in the cycle right after the completion. The gap value is sampled only when a count is loaded.

Top module: `dtl_limiter`

## Requirements
- R1: During and after reset, with no request pending, `req_ready` is 1, `bus_issue` is 0 and `busy` is 0.
- R2: `bus_issue` is 1 in exactly the cycles where `req_valid` and `req_ready` are both 1. After an issue, `req_ready` is 0 and `busy` is 1 until the cycle after `bus_done` is seen.
- R3: With `cfg_enable`=1 and `cfg_gap`=N (N>0), `req_ready` stays 0 for exactly N cycles after the cycle in which `bus_done` ends an access. It is 1 in the cycle after those N.
- R4: With `cfg_enable`=0, `req_ready` is 1 in the cycle right after the completing `bus_done`.
- R5: A `cfg_gap` of 0 with `cfg_enable`=1 gives the same timing as R4: no idle cycles are added.
- R6: Changing `cfg_gap` while a gap is being counted does not change the length of that gap. The new value applies at the next completion.
- R7: A request held on `req_valid` during the gap is not issued while `req_ready` is 0. It is issued in the first cycle `req_ready` returns to 1.
- R8: Clearing `cfg_enable` while a gap is running ends the gap. `req_ready` is 1 in the next cycle.
- R9: The largest gap value, 255, gives exactly 255 idle cycles.
- R10: A `bus_done` pulse has no effect when no access is outstanding, whether the block is idle or in a gap. It neither delays readiness nor restarts a running gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus master port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Engine has an access to issue |
| req_ready | output | 1 | Limiter allows an issue this cycle |
| bus_issue | output | 1 | Access issued to the bus this cycle |
| bus_done | input | 1 | One-cycle pulse: outstanding access finished |
| cfg_enable | input | 1 | 1 enables dead-time insertion |
| cfg_gap | input | 8 | Idle cycles inserted after each access |
| busy | output | 1 | Access outstanding or gap running |

## Verification
The state that matters is the count of remaining gap cycles and whether an access is outstanding. A wrong count shows up at `req_ready` as a gap that is too long or too short. The bench measures this to the exact cycle, from the completion until readiness returns. A lost access-outstanding state shows up one cycle after an issue, as `req_ready` going high early. A wrongly sampled gap value or a restarted gap only shows up when the gap ends, up to 255 cycles later. For that reason the bench changes the configuration and pulses `bus_done` in the middle of long gaps.

// File: rtl/dtl_pkg.sv
// Package: shared types for the dead-time limiter.
// Assumes: nothing beyond the standard language.
package dtl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } dtl_state_e;
endpackage

// File: rtl/dtl_gap_counter.sv
// Module: loadable down-counter that measures the idle gap.
// Assumes: load and dec are never asserted together. The count is held
// when neither one is asserted.
module dtl_gap_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count register: reload, decrement or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - ONE;
    end

    // Final gap cycle flag.
    always_comb last = (cnt == ONE);
endmodule

// File: rtl/dtl_issue_fsm.sv
// Module: control of access issue, access tracking and gap state.
// Assumes: bus_done arrives at the earliest one cycle after the issue,
// and bus_done outside an outstanding access is meaningless.
module dtl_issue_fsm
    import dtl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_done,
    input  logic enable,
    input  logic gap_nonzero,
    input  logic gap_last,
    output logic ready,
    output logic in_access,
    output logic in_gap,
    output logic cnt_load,
    output logic cnt_dec
);
    dtl_state_e st, st_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next-state and counter control.
    always_comb begin
        st_nxt   = st;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) st_nxt = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (bus_done) begin
                    if (enable && gap_nonzero) begin
                        st_nxt   = ST_GAP;
                        cnt_load = 1'b1;
                    end else begin
                        st_nxt = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                cnt_dec = 1'b1;
                if (!enable || gap_last) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State decode to outputs.
    always_comb begin
        ready     = (st == ST_IDLE);
        in_access = (st == ST_ACCESS);
        in_gap    = (st == ST_GAP);
    end
endmodule

// File: rtl/dtl_limiter.sv
// Module: top of the bus access dead-time limiter. Stalls the engine's
// request for cfg_gap idle cycles after each completed access.
// Assumes: a single outstanding access at a time, and the same clock for
// the engine and the bus port.
module dtl_limiter #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             bus_issue,
    input  logic             bus_done,
    input  logic             cfg_enable,
    input  logic [GAP_W-1:0] cfg_gap,
    output logic             busy
);
    logic             in_access;
    logic             in_gap;
    logic             cnt_load;
    logic             cnt_dec;
    logic             gap_last;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_nonzero;

    // Zero gap detect.
    always_comb gap_nonzero = (cfg_gap != '0);

    dtl_issue_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bus_done   (bus_done),
        .enable     (cfg_enable),
        .gap_nonzero(gap_nonzero),
        .gap_last   (gap_last),
        .ready      (req_ready),
        .in_access  (in_access),
        .in_gap     (in_gap),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec)
    );

    dtl_gap_counter #(.CNT_W(GAP_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cfg_gap),
        .dec     (cnt_dec),
        .cnt     (gap_cnt),
        .last    (gap_last)
    );

    // Handshake and status outputs.
    always_comb begin
        bus_issue = req_valid && req_ready;
        busy      = in_access || in_gap;
    end
endmodule

// File: rtl/dtl_limiter_chk.sv
// Module: property checker for dtl_limiter, attached with bind.
// Assumes: it is bound to the top, so internal state names resolve.
module dtl_limiter_chk #(
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             bus_issue,
    input logic             bus_done,
    input logic             cfg_enable,
    input logic [GAP_W-1:0] cfg_gap,
    input logic             busy,
    input logic             in_access,
    input logic             in_gap,
    input logic [GAP_W-1:0] gap_cnt
);
    // R2
    issue_then_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_issue |=> (busy && !req_ready));

    // R3
    gap_holds_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && cfg_enable && gap_cnt > GAP_W'(1)) |=> !req_ready);

    // R6
    gap_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && cfg_enable && gap_cnt > GAP_W'(1)) |=> (gap_cnt == $past(gap_cnt) - GAP_W'(1)));

    // R4
    disabled_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && bus_done && !cfg_enable) |=> req_ready);

    // R5
    zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_access && bus_done && cfg_gap == '0) |=> req_ready);

    // R8
    disable_ends_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && !cfg_enable) |=> req_ready);

    // R10
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);
endmodule

bind dtl_limiter dtl_limiter_chk #(.GAP_W(GAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_issue (bus_issue),
    .bus_done  (bus_done),
    .cfg_enable(cfg_enable),
    .cfg_gap   (cfg_gap),
    .busy      (busy),
    .in_access (in_access),
    .in_gap    (in_gap),
    .gap_cnt   (gap_cnt)
);

// File: tb/dtl_limiter_tb.sv
// Bench: directed scenarios for dtl_limiter. Inputs are driven and outputs
// sampled at the falling edge.
module dtl_limiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       bus_done = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [7:0] cfg_gap = 8'd0;
    logic       req_ready, bus_issue, busy;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    dtl_limiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .bus_issue(bus_issue), .bus_done(bus_done), .cfg_enable(cfg_enable),
        .cfg_gap(cfg_gap), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one access and complete it. Returns at the negedge after the done edge.
    task automatic access(input int lat);
        req_valid = 1'b1;
        #1 check("R2 issue", bus_issue, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 ready low", req_ready, 0);
        check("R2 busy", busy, 1);
        for (int i = 0; i < lat; i++) @(negedge clk);
        check("R2 still blocked", req_ready, 0);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
    endtask

    // Count the cycles with ready low, starting at the current negedge.
    task automatic measure(output int n);
        n = 0;
        while (!req_ready && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready", req_ready, 1);
        check("R1 issue", bus_issue, 0);
        check("R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after", req_ready, 1);
        check("R1 busy after", busy, 0);
    endtask

    task automatic t_gap(input string req, input logic en, input int gap, input int exp);
        int n;
        cfg_enable = en;
        cfg_gap = 8'(gap);
        access(2);
        measure(n);
        check(req, n, exp);
        check({req, " busy clear"}, busy, 0);
    endtask

    task automatic t_gap_change;
        int n;
        cfg_enable = 1'b1;
        cfg_gap = 8'd6;
        access(1);
        @(negedge clk);
        cfg_gap = 8'd40;
        measure(n);
        check("R6 old gap kept", n + 1, 6);
        access(0);
        measure(n);
        check("R6 new gap used", n, 40);
    endtask

    task automatic t_held_req;
        int n = 0;
        cfg_enable = 1'b1;
        cfg_gap = 8'd4;
        access(1);
        req_valid = 1'b1;
        #1;
        while (!req_ready && n < 50) begin
            check("R7 no issue in gap", bus_issue, 0);
            n++;
            @(negedge clk);
            #1;
        end
        check("R7 gap length", n, 4);
        check("R7 issued", bus_issue, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 access taken", busy, 1);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        measure(n);
    endtask

    task automatic t_disable_mid;
        cfg_enable = 1'b1;
        cfg_gap = 8'd50;
        access(1);
        @(negedge clk);
        @(negedge clk);
        check("R8 in gap", req_ready, 0);
        cfg_enable = 1'b0;
        @(negedge clk);
        check("R8 gap ended", req_ready, 1);
        cfg_enable = 1'b1;
    endtask

    task automatic t_stray_done;
        int n;
        cfg_enable = 1'b1;
        cfg_gap = 8'd5;
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        check("R10 idle done ignored", req_ready, 1);
        check("R10 idle busy", busy, 0);
        access(1);
        @(negedge clk);
        cfg_gap = 8'd30;
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        measure(n);
        check("R10 gap not restarted", n + 2, 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_gap("R3 gap 3", 1'b1, 3, 3);
        t_gap("R3 gap 1", 1'b1, 1, 1);
        t_gap("R3 gap 17", 1'b1, 17, 17);
        t_gap("R4 disabled", 1'b0, 9, 0);
        t_gap("R5 zero gap", 1'b1, 0, 0);
        t_gap_change();
        t_held_req();
        t_disable_mid();
        t_stray_done();
        t_gap("R9 max gap", 1'b1, 255, 255);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule